// File: doc/BRIEF.md
# Service Gate Capture Sequencer

This block sits in a device adapter on a channel that shares its data and tag lines among many devices. When a poll for a cycle-steal or interrupt request stops at this device, the adapter must decide whether it is the device being serviced. When the channel then raises service gate, the adapter answers with a service-gate return tag, and only the chosen device may do so. A data strobe that belongs to a storage transfer must never draw a return from a device that was not chosen.

Two state bits carry the decision. A poll capture latch records that the poll was taken here. A capture trigger sets when the poll was captured, service gate is active and the device address on the bus matches. The trigger, once set, clears the poll capture latch. This order means the trigger is already firmly set before the condition that set it goes away. The trigger holds until both service gate and data strobe have dropped, whichever drops last. Two envelopes come from the trigger: a gate envelope, and a strobe envelope that is the gate envelope combined with data strobe. The device uses them to gate data and condition codes onto the interface. Each envelope drives its return tag through a cycle-count delay.

Top module: `service_gate_capture`

## Requirements
- R1: While rst_n is low at a clock edge, all four outputs are low on the following cycle.
- R2: The capture trigger (seen as sel_env) sets only when the poll capture latch is set, service gate is active and address bus bits 15:0 equal DEV_ADDR. Bus bit 16 has no effect on this decision.
- R3: Data strobe never sets the capture trigger: with service gate inactive, no pattern of data strobe, poll or address raises sel_env.
- R4: The cycle after the trigger sets, the poll capture latch clears. A later rise of service gate therefore does not select the device again until a new poll is captured.
- R5: Once set, the trigger stays set while the synchronized service gate or data strobe is active. It clears on the edge after both are inactive, whichever fell last.
- R6: Each return tag rises DELAY+1 cycles after its envelope rises (GATE_DELAY for sel_ret, STROBE_DELAY for stb_ret). It falls in the same cycle as its envelope, and it is never high while its envelope is low.
- R7: A high level on any of the three chan_rst bits at a clock edge clears the trigger and the poll capture latch, so both envelopes and both tags are low on the following cycle.
- R8: stb_env is high exactly when the trigger is set and the synchronized data strobe is active. A data strobe with no selection produces no envelope and no tag.
- R9: poll_hit_a, svc_gate_a, data_strobe_a and addr_bus pass through a two-stage synchronizer. With poll and gate raised together, sel_env rises at the fourth clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Adapter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_hit_a | input | 1 | Asynchronous: the poll was captured by this device |
| svc_gate_a | input | 1 | Asynchronous service gate from the channel |
| data_strobe_a | input | 1 | Asynchronous data strobe from the channel |
| addr_bus | input | ADDR_W+1 | Device address bus; the top bit (bit 16) is ignored |
| chan_rst | input | 3 | Three synchronous channel-directed resets, active high |
| sel_env | output | 1 | Gate envelope: the device is selected for service |
| stb_env | output | 1 | Strobe envelope: selected and data strobe active |
| sel_ret | output | 1 | Delayed service-gate return tag |
| stb_ret | output | 1 | Delayed data-strobe return tag |

## Verification
On every cycle the assertions check the following. The trigger only rises from a captured poll with gate and address match. The poll latch empties once the trigger is set. The trigger holds while either strobe lingers. Tags stay inside their envelopes, and the strobe envelope implies selection. Any channel reset empties both state bits. The bench scenarios alone show the exact latencies through the synchronizer and the tag counters, that address bit 16 is ignored, and that a released device is not selected again without a fresh poll. They also show that storage strobes draw nothing from an unselected device.

// File: rtl/sgc_pkg.sv
// Shared definitions for the service gate capture sequencer.
// Assumes: one gate tag and one strobe tag per device adapter.
package sgc_pkg;
    localparam int NUM_TAGS  = 2;
    localparam int NUM_CRST  = 3;

    // Index of each return tag in the tag vectors
    typedef enum int {
        TAG_GATE   = 0,
        TAG_STROBE = 1
    } tag_idx_e;

    // Channel control lines carried through the synchronizer together
    typedef struct packed {
        logic poll_hit;
        logic svc_gate;
        logic data_strobe;
    } chan_ctl_t;
endpackage

// File: rtl/sgc_sync.sv
// Multi-stage synchronizer for asynchronous interface inputs.
// Assumes: each bit is independent; a bus sampled here must be stable
// around the edges where it is used.
module sgc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the input through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sgc_capture.sv
// Poll capture latch and service gate capture trigger.
// The trigger sets from a captured poll, active gate and address match.
// Data strobe only holds it. The set trigger clears the poll latch.
// Assumes: all inputs already synchronous to clk.
module sgc_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic poll_hit,
    input  logic svc_gate,
    input  logic data_strobe,
    input  logic addr_ok,
    input  logic crst_any,
    output logic poll_q,
    output logic trig_q
);
    logic set_trig;
    logic release_ok;

    assign set_trig   = poll_q & svc_gate & addr_ok;
    assign release_ok = ~svc_gate & ~data_strobe;

    // Capture trigger: set by selection, released after both strobes fall
    always_ff @(posedge clk) begin
        if (!rst_n || crst_any) begin
            trig_q <= 1'b0;
        end else if (trig_q) begin
            if (release_ok) trig_q <= 1'b0;
        end else if (set_trig) begin
            trig_q <= 1'b1;
        end
    end

    // Poll capture latch: set by poll, held clear while the trigger is set
    always_ff @(posedge clk) begin
        if (!rst_n || crst_any) begin
            poll_q <= 1'b0;
        end else if (trig_q) begin
            poll_q <= 1'b0;
        end else if (poll_hit) begin
            poll_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sgc_tag_delay.sv
// Return-tag delay: a counter loaded with DELAY when the envelope rises.
// The tag rises once the counter is empty and falls with the envelope.
// Assumes: env is synchronous to clk.
module sgc_tag_delay #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic env,
    output logic tag
);
    localparam int CW = (DELAY < 1) ? 1 : $clog2(DELAY + 1);
    localparam logic [CW-1:0] LOAD = CW'(DELAY);

    logic [CW-1:0] cnt;
    logic          env_q;

    // Load on envelope rise, count down while the envelope lasts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            env_q <= 1'b0;
        end else begin
            env_q <= env;
            if (env && !env_q)           cnt <= LOAD;
            else if (env && cnt != '0)   cnt <= cnt - 1'b1;
        end
    end

    assign tag = env & env_q & (cnt == '0);
endmodule

// File: rtl/service_gate_capture.sv
// Service gate capture sequencer top.
// Synchronizes the channel lines and decides selection from the poll
// capture, gate and address (top bus bit ignored). Forms the two
// envelopes and delays each into its return tag.
// Assumes: chan_rst is already synchronous to clk.
module service_gate_capture #(
    parameter int                ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] DEV_ADDR     = 16'h00A5,
    parameter int                SYNC_STAGES  = 2,
    parameter int                GATE_DELAY   = 3,
    parameter int                STROBE_DELAY = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            poll_hit_a,
    input  logic            svc_gate_a,
    input  logic            data_strobe_a,
    input  logic [ADDR_W:0] addr_bus,
    input  logic [2:0]      chan_rst,
    output logic            sel_env,
    output logic            stb_env,
    output logic            sel_ret,
    output logic            stb_ret
);
    import sgc_pkg::*;

    localparam int            BUS_W = ADDR_W + 1;
    localparam logic [BUS_W-1:0] CMP_MASK = {1'b0, {ADDR_W{1'b1}}};
    localparam logic [BUS_W-1:0] CMP_ADDR = {1'b0, DEV_ADDR};

    chan_ctl_t            ctl_a, ctl_s;
    logic [BUS_W-1:0]     addr_s;
    logic                 sg_s, ds_s, poll_s;
    logic                 addr_ok, crst_any;
    logic                 poll_q, trig_q;
    logic [NUM_TAGS-1:0]  env_v, tag_v;

    assign ctl_a = '{poll_hit: poll_hit_a, svc_gate: svc_gate_a,
                     data_strobe: data_strobe_a};

    sgc_sync #(.W($bits(chan_ctl_t)), .STAGES(SYNC_STAGES)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d(ctl_a), .q(ctl_s)
    );

    sgc_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d(addr_bus), .q(addr_s)
    );

    assign poll_s   = ctl_s.poll_hit;
    assign sg_s     = ctl_s.svc_gate;
    assign ds_s     = ctl_s.data_strobe;
    assign addr_ok  = ((addr_s ^ CMP_ADDR) & CMP_MASK) == '0;
    assign crst_any = |chan_rst;

    sgc_capture u_capture (
        .clk(clk), .rst_n(rst_n), .poll_hit(poll_s), .svc_gate(sg_s),
        .data_strobe(ds_s), .addr_ok(addr_ok), .crst_any(crst_any),
        .poll_q(poll_q), .trig_q(trig_q)
    );

    assign env_v[TAG_GATE]   = trig_q;
    assign env_v[TAG_STROBE] = trig_q & ds_s;

    // One delay per return tag, each with its own count
    for (genvar i = 0; i < NUM_TAGS; i++) begin : g_tag
        localparam int D = (i == TAG_GATE) ? GATE_DELAY : STROBE_DELAY;
        sgc_tag_delay #(.DELAY(D)) u_dly (
            .clk(clk), .rst_n(rst_n), .env(env_v[i]), .tag(tag_v[i])
        );
    end

    assign sel_env = env_v[TAG_GATE];
    assign stb_env = env_v[TAG_STROBE];
    assign sel_ret = tag_v[TAG_GATE];
    assign stb_ret = tag_v[TAG_STROBE];
endmodule

// File: rtl/sgc_checker.sv
// Cycle-by-cycle properties of the service gate capture sequencer.
// Attached to the top module by the bind statement at the end of the file.
module sgc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       poll_q,
    input logic       sg_s,
    input logic       ds_s,
    input logic       addr_ok,
    input logic [2:0] chan_rst,
    input logic       sel_env,
    input logic       stb_env,
    input logic       sel_ret,
    input logic       stb_ret
);
    // R2: the trigger rises only from a captured poll with gate and match
    p_set_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_env) |-> $past(poll_q & sg_s & addr_ok));

    // R3: a rise of the trigger always had service gate behind it
    p_no_strobe_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_env) |-> $past(sg_s));

    // R4: the poll latch empties once the trigger is set
    p_poll_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_env |=> !poll_q);

    // R5: the trigger holds while either strobe lingers
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_env && (sg_s || ds_s) && chan_rst == 3'b000) |=> sel_env);

    // R6: each tag lies inside its envelope
    p_gate_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ret |-> sel_env);
    p_strobe_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_ret |-> stb_env);

    // R7: any channel reset empties both state bits
    p_chan_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rst != 3'b000) |=> (!sel_env && !poll_q));

    // R8: the strobe envelope implies selection
    p_strobe_env_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stb_env |-> sel_env);
endmodule

bind service_gate_capture sgc_checker u_sgc_checker (
    .clk(clk), .rst_n(rst_n), .poll_q(poll_q), .sg_s(sg_s), .ds_s(ds_s),
    .addr_ok(addr_ok), .chan_rst(chan_rst), .sel_env(sel_env),
    .stb_env(stb_env), .sel_ret(sel_ret), .stb_ret(stb_ret)
);

// File: tb/service_gate_capture_bench.sv
// Bench: directed corner cases, then seeded random traffic, all compared
// against a cycle model written from the requirements.
module service_gate_capture_bench;
    localparam int          ADDR_W = 16;
    localparam logic [15:0] DEV    = 16'h00A5;
    localparam int          GD     = 3;
    localparam int          SD     = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll_hit_a = 1'b0, svc_gate_a = 1'b0, data_strobe_a = 1'b0;
    logic [16:0] addr_bus = '0;
    logic [2:0]  chan_rst = '0;
    logic        sel_env, stb_env, sel_ret, stb_ret;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    service_gate_capture #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV),
        .GATE_DELAY(GD), .STROBE_DELAY(SD)) u_service_gate_capture (
        .clk(clk), .rst_n(rst_n), .poll_hit_a(poll_hit_a),
        .svc_gate_a(svc_gate_a), .data_strobe_a(data_strobe_a),
        .addr_bus(addr_bus), .chan_rst(chan_rst), .sel_env(sel_env),
        .stb_env(stb_env), .sel_ret(sel_ret), .stb_ret(stb_ret)
    );

    // ---------------- reference model from the requirements ----------
    logic [2:0]  m1, m2;          // {poll, gate, strobe} sync stages (R9)
    logic [16:0] a1, a2;
    logic        m_poll, m_trig;
    int          m_cnt [2];
    logic        m_envq [2];

    function automatic logic addr_hit(input logic [16:0] a);
        return a[15:0] == DEV;    // R2: bit 16 ignored
    endfunction

    function automatic logic exp_env(input int i);
        return (i == 0) ? m_trig : (m_trig & m2[0]);   // R8
    endfunction

    function automatic logic exp_tag(input int i);
        return exp_env(i) & m_envq[i] & (m_cnt[i] == 0); // R6
    endfunction

    // Advance the model one clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m1 <= '0; m2 <= '0; a1 <= '0; a2 <= '0;
            m_poll <= 1'b0; m_trig <= 1'b0;
            for (int i = 0; i < 2; i++) begin m_cnt[i] <= 0; m_envq[i] <= 1'b0; end
        end else begin
            m1 <= {poll_hit_a, svc_gate_a, data_strobe_a};
            m2 <= m1;
            a1 <= addr_bus;
            a2 <= a1;
            if (|chan_rst)                        m_trig <= 1'b0;  // R7
            else if (m_trig)                      m_trig <= m2[1] | m2[0]; // R5
            else if (m_poll && m2[1] && addr_hit(a2)) m_trig <= 1'b1; // R2 R3
            if (|chan_rst || m_trig)              m_poll <= 1'b0;  // R4 R7
            else if (m2[2])                       m_poll <= 1'b1;
            for (int i = 0; i < 2; i++) begin
                m_envq[i] <= exp_env(i);
                if (exp_env(i) && !m_envq[i])       m_cnt[i] <= (i == 0) ? GD : SD;
                else if (exp_env(i) && m_cnt[i] != 0) m_cnt[i] <= m_cnt[i] - 1;
            end
        end
    end

    task automatic check(input logic act, input logic expv, input string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", what, act, expv, $time);
        end
    endtask

    // Wait for the next falling edge and compare every output with the model
    task automatic tick();
        @(negedge clk);
        check(sel_env, exp_env(0), "R2 R5 R7 sel_env vs model");
        check(stb_env, exp_env(1), "R8 stb_env vs model");
        check(sel_ret, exp_tag(0), "R6 sel_ret vs model");
        check(stb_ret, exp_tag(1), "R6 stb_ret vs model");
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Poll captured with gate, right address, top bit set
    task automatic select_device();
        addr_bus   = {1'b1, DEV};
        poll_hit_a = 1'b1;
        svc_gate_a = 1'b1;
        tick();
        poll_hit_a = 1'b0;
    endtask

    initial begin
        // R1: reset state
        ticks(3);
        check(sel_env, 1'b0, "R1 sel_env in reset");
        check(stb_env, 1'b0, "R1 stb_env in reset");
        check(sel_ret, 1'b0, "R1 sel_ret in reset");
        check(stb_ret, 1'b0, "R1 stb_ret in reset");
        rst_n = 1'b1;
        ticks(2);

        // R9 R2: selection latency, bit 16 set on the bus
        select_device();                       // edge 1 done
        ticks(2);
        check(sel_env, 1'b0, "R9 sel_env before fourth edge");
        tick();
        check(sel_env, 1'b1, "R9 R2 sel_env at fourth edge, bit16 ignored");
        // R6: gate tag DELAY+1 edges after envelope rise
        ticks(GD);
        check(sel_ret, 1'b0, "R6 sel_ret one cycle early");
        tick();
        check(sel_ret, 1'b1, "R6 sel_ret after GATE_DELAY+1");

        // R8: strobe envelope follows strobe while selected
        data_strobe_a = 1'b1;
        ticks(2);
        check(stb_env, 1'b1, "R8 stb_env with selection");
        // R5: gate falls first, strobe holds the trigger
        svc_gate_a = 1'b0;
        ticks(4);
        check(sel_env, 1'b1, "R5 held by late strobe");
        data_strobe_a = 1'b0;
        ticks(2);
        check(sel_env, 1'b1, "R5 still held before release edge");
        tick();
        check(sel_env, 1'b0, "R5 released after last strobe falls");
        check(sel_ret, 1'b0, "R6 tag drops with envelope");

        // R4: no reselection without a new poll
        svc_gate_a = 1'b1;
        ticks(6);
        check(sel_env, 1'b0, "R4 no reselect without poll");
        svc_gate_a = 1'b0;
        ticks(3);

        // R3 R8: storage strobes with poll but no gate
        data_strobe_a = 1'b1;
        poll_hit_a    = 1'b1;
        tick();
        poll_hit_a    = 1'b0;
        ticks(5);
        check(sel_env, 1'b0, "R3 strobe cannot set trigger");
        check(stb_env, 1'b0, "R8 unselected strobe gives no envelope");
        check(stb_ret, 1'b0, "R8 unselected strobe gives no tag");
        data_strobe_a = 1'b0;
        // R7: channel reset empties the captured poll
        chan_rst = 3'b010;
        tick();
        chan_rst = 3'b000;
        svc_gate_a = 1'b1;
        ticks(5);
        check(sel_env, 1'b0, "R7 reset cleared poll capture");
        svc_gate_a = 1'b0;
        ticks(3);

        // R2: wrong address is not selected
        addr_bus   = {1'b0, DEV ^ 16'h0001};
        poll_hit_a = 1'b1;
        svc_gate_a = 1'b1;
        tick();
        poll_hit_a = 1'b0;
        ticks(5);
        check(sel_env, 1'b0, "R2 address mismatch");
        svc_gate_a = 1'b0;
        chan_rst   = 3'b001;
        tick();
        chan_rst   = 3'b000;
        ticks(3);

        // R7: channel reset while selected
        select_device();
        ticks(5);
        check(sel_env, 1'b1, "R7 precondition selected");
        chan_rst = 3'b100;
        tick();
        chan_rst = 3'b000;
        check(sel_env, 1'b0, "R7 reset deselects");
        check(sel_ret, 1'b0, "R7 reset removes tag");
        svc_gate_a = 1'b0;
        ticks(3);

        // Random traffic against the model
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            poll_hit_a    = (r < 8);
            if ($urandom_range(0, 9) == 0) svc_gate_a    = ~svc_gate_a;
            if ($urandom_range(0, 7) == 0) data_strobe_a = ~data_strobe_a;
            if ($urandom_range(0, 11) == 0)
                addr_bus = ($urandom_range(0, 2) != 0) ?
                           {1'($urandom_range(0, 1)), DEV} : 17'($urandom());
            chan_rst = ($urandom_range(0, 149) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
            tick();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule